// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the bus-write path of a flash memory controller and turns a stream of single bus writes into multi-write flash commands. A command is only taken after two exact unlock writes (fixed address and fixed data). The third write picks the command: enter identifier mode, program one location, or enter a fast program mode that skips the unlock writes. A single reset write, or the unlock pair followed by the reset value, returns the block to plain array reads. Any write that does not fit the expected sequence sends the block back to array reads.

The block tracks what a bus read should return and reports it as a read-source code plus a 16-bit identifier value. The array, the status register and the program engine are outside. A program request goes to the engine as a valid/ready transfer carrying the target address and data. A program aimed at a write-protected block is dropped with no request and no error. The engine reports completion with a done pulse, qualified by an error flag.

Bus writes come in as a valid/ready stream. `wr_ready` is low exactly while a program request waits for the engine. A write is taken only on a cycle where both `wr_valid` and `wr_ready` are high. The engine may hold `prog_ready` low for any number of cycles. During that time `prog_valid`, `prog_addr` and `prog_data` stay constant.

Top module: `fcd_top`

## Requirements
- R1: After reset the read source is 0 (array), `prog_valid` is 0 and `wr_ready` is 1.
- R2: A write of data F0 to any address returns the block to array reads (source 0) from any state except busy and fast-program mode. So does a valid unlock pair followed by F0 at any address. Either form also clears the error state.
- R3: Unlock writes compare only data bits 7:0 and the low address key. In word mode (`byte_mode`=0) the key is `wr_addr[10:0]`, and the two unlock writes need 555h with data AAh, then 2AAh with data 55h. In byte mode the key is {`wr_addr[10:0]`, `wr_alsb`}, and the two unlock writes need AAAh then 555h. The command write uses the first unlock address. All other address and data bits are ignored.
- R4: A write that breaks an unlock or command sequence returns the block to array reads. If the sequence began in the error state, the block goes back to the error state.
- R5: An unlock pair, then command A0h, then a target write causes `prog_valid`=1 from the next cycle. The request carries `prog_addr`={`wr_addr`,`wr_alsb`} and `prog_data`=`wr_data` of the target write. The read source becomes 4 (status).
- R6: If the target write falls in a block whose `blk_prot` bit is set, no request is raised and no error is flagged. The block index is `wr_addr[17:12]`. The block returns to array reads, or to fast-program mode if the program was started there.
- R7: While busy, writes are accepted but have no effect, and the read source is 4. On `op_done` with `op_err`=0, the block returns to array reads, or to fast-program mode if the program started there.
- R8: `prog_valid` stays high with stable address and data until a cycle with `prog_ready`=1. `wr_ready` is the inverse of `prog_valid`.
- R9: `op_done` with `op_err`=1 while busy enters the error state. The read source stays 4 until one of the reset forms of R2 is written.
- R10: An unlock pair followed by command 90h enters identifier mode. There the source depends on `rd_addr[1:0]`: 00 gives source 1 with `rd_id`=0020h, 01 gives source 2 with `rd_id`=device code (default 00EEh), 10 gives source 3 with `rd_id`=1 if `blk_prot[rd_addr[17:12]]` is set and 0 otherwise, and 11 gives source 0. The mode lasts until the next write. `rd_id` is 0 for sources 0 and 4.
- R11: An unlock pair followed by command 20h enters fast-program mode (source 0). In this mode, data A0h then a target write programs as in R5 and R6. Data 90h then data 00h leaves to array reads. Any other write leaves the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Bus write offered |
| wr_ready | output | 1 | Bus write can be taken |
| wr_addr | input | 18 | Word address of the write |
| wr_alsb | input | 1 | Extra low address bit, used in byte mode |
| wr_data | input | 16 | Write data |
| byte_mode | input | 1 | 1 = 8-bit bus organisation |
| blk_prot | input | 64 | Per-block write-protect flags |
| rd_addr | input | 18 | Address of the current bus read |
| rd_src | output | 3 | Read source: 0 array, 1 maker code, 2 device code, 3 protect flag, 4 status |
| rd_id | output | 16 | Identifier value for sources 1 to 3 |
| prog_valid | output | 1 | Program request pending |
| prog_ready | input | 1 | Engine takes the request |
| prog_addr | output | 19 | Target address {word address, low bit} |
| prog_data | output | 16 | Target data |
| op_done | input | 1 | Program operation finished |
| op_err | input | 1 | Finished with error (qualifies op_done) |

## Verification
The completion pulse can land on the same edge as an incoming bus write. The decoder must then take the state change from the completion and drop the write, because at that edge it is still busy. Random stimulus raises `op_done` on many busy cycles while writes keep streaming. A second overlap is a write offered while a program request is held by `prog_ready`=0, which must not be taken. A bench-side model judges both overlaps by predicting the read source, the identifier value and the program port after every cycle.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [3:0] {
    ST_READ, ST_UNL1, ST_UNL2, ST_PGM_ARG, ST_AUTO,
    ST_BUSY, ST_ERR, ST_BYP, ST_BYP_PGM, ST_BYP_RST
  } fcd_state_e;

  typedef enum logic [2:0] {
    SRC_ARRAY  = 3'd0,
    SRC_MFR    = 3'd1,
    SRC_DEV    = 3'd2,
    SRC_PROT   = 3'd3,
    SRC_STATUS = 3'd4
  } rd_src_e;

  localparam logic [7:0] CMD_KEY_A    = 8'hAA;
  localparam logic [7:0] CMD_KEY_B    = 8'h55;
  localparam logic [7:0] CMD_IDENT    = 8'h90;
  localparam logic [7:0] CMD_PROGRAM  = 8'hA0;
  localparam logic [7:0] CMD_FASTMODE = 8'h20;
  localparam logic [7:0] CMD_RESET    = 8'hF0;
  localparam logic [7:0] CMD_FAST_OUT = 8'h00;
  localparam logic [15:0] MAKER_CODE  = 16'h0020;
endpackage

// File: rtl/fcd_addr_match.sv
module fcd_addr_match #(
  parameter int KEY_W = 11
) (
  input  logic [KEY_W-1:0] key_addr,
  input  logic             alsb,
  input  logic             byte_mode,
  output logic             hit_first,
  output logic             hit_second
);
  localparam int FULL_W = KEY_W + 1;
  localparam logic [FULL_W-1:0] WORD_FIRST  = FULL_W'(12'h555);
  localparam logic [FULL_W-1:0] WORD_SECOND = FULL_W'(12'h2AA);
  localparam logic [FULL_W-1:0] BYTE_FIRST  = FULL_W'(12'hAAA);
  localparam logic [FULL_W-1:0] BYTE_SECOND = FULL_W'(12'h555);

  logic [FULL_W-1:0] key;

  always_comb begin
    key = byte_mode ? {key_addr, alsb} : {1'b0, key_addr};
    hit_first  = byte_mode ? (key == BYTE_FIRST)  : (key == WORD_FIRST);
    hit_second = byte_mode ? (key == BYTE_SECOND) : (key == WORD_SECOND);
  end
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import fcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic       hit_first,
  input  logic       hit_second,
  input  logic [7:0] cmd,
  input  logic       tgt_prot,
  input  logic       op_done,
  input  logic       op_err,
  output fcd_state_e state,
  output logic       launch
);
  fcd_state_e nxt;
  logic from_err, from_err_n;
  logic fast_ret, fast_ret_n;
  fcd_state_e fallback;

  always_comb begin
    fallback   = from_err ? ST_ERR : ST_READ;
    nxt        = state;
    from_err_n = from_err;
    fast_ret_n = fast_ret;
    launch     = 1'b0;
    if (state == ST_BUSY) begin
      if (op_done) nxt = op_err ? ST_ERR : (fast_ret ? ST_BYP : ST_READ);
    end else if (fire) begin
      unique case (state)
        ST_READ, ST_AUTO, ST_ERR: begin
          if (cmd == CMD_RESET) nxt = ST_READ;
          else if (hit_first && cmd == CMD_KEY_A) begin
            nxt        = ST_UNL1;
            from_err_n = (state == ST_ERR);
          end else nxt = (state == ST_ERR) ? ST_ERR : ST_READ;
        end
        ST_UNL1: nxt = (hit_second && cmd == CMD_KEY_B) ? ST_UNL2 : fallback;
        ST_UNL2: begin
          if (cmd == CMD_RESET) nxt = ST_READ;
          else if (hit_first && !from_err) begin
            unique case (cmd)
              CMD_IDENT:    nxt = ST_AUTO;
              CMD_PROGRAM:  nxt = ST_PGM_ARG;
              CMD_FASTMODE: nxt = ST_BYP;
              default:      nxt = ST_READ;
            endcase
          end else nxt = fallback;
        end
        ST_PGM_ARG: begin
          launch     = !tgt_prot;
          fast_ret_n = 1'b0;
          nxt        = tgt_prot ? ST_READ : ST_BUSY;
        end
        ST_BYP: begin
          if (cmd == CMD_PROGRAM) nxt = ST_BYP_PGM;
          else if (cmd == CMD_IDENT) nxt = ST_BYP_RST;
        end
        ST_BYP_PGM: begin
          launch     = !tgt_prot;
          fast_ret_n = 1'b1;
          nxt        = tgt_prot ? ST_BYP : ST_BUSY;
        end
        ST_BYP_RST: nxt = (cmd == CMD_FAST_OUT) ? ST_READ : ST_BYP;
        default: nxt = ST_READ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_READ;
      from_err <= 1'b0;
      fast_ret <= 1'b0;
    end else begin
      state    <= nxt;
      from_err <= from_err_n;
      fast_ret <= fast_ret_n;
    end
  end
endmodule

// File: rtl/fcd_prog_port.sv
module fcd_prog_port #(
  parameter int PA_W = 19,
  parameter int DW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            launch,
  input  logic [PA_W-1:0] tgt_addr,
  input  logic [DW-1:0]   tgt_data,
  input  logic            prog_ready,
  output logic            prog_valid,
  output logic [PA_W-1:0] prog_addr,
  output logic [DW-1:0]   prog_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_valid <= 1'b0;
      prog_addr  <= '0;
      prog_data  <= '0;
    end else if (launch) begin
      prog_valid <= 1'b1;
      prog_addr  <= tgt_addr;
      prog_data  <= tgt_data;
    end else if (prog_ready) begin
      prog_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/fcd_read_mux.sv
module fcd_read_mux
  import fcd_pkg::*;
#(
  parameter int          BLK_W    = 6,
  parameter logic [15:0] DEV_CODE = 16'h00EE
) (
  input  fcd_state_e               state,
  input  logic [1:0]               rd_sel,
  input  logic [BLK_W-1:0]         rd_blk,
  input  logic [(1<<BLK_W)-1:0]    blk_prot,
  output logic [2:0]               rd_src,
  output logic [15:0]              rd_id
);
  rd_src_e src;

  always_comb begin
    unique case (state)
      ST_BUSY, ST_ERR: src = SRC_STATUS;
      ST_AUTO: begin
        unique case (rd_sel)
          2'b00:   src = SRC_MFR;
          2'b01:   src = SRC_DEV;
          2'b10:   src = SRC_PROT;
          default: src = SRC_ARRAY;
        endcase
      end
      default: src = SRC_ARRAY;
    endcase
    unique case (src)
      SRC_MFR:  rd_id = MAKER_CODE;
      SRC_DEV:  rd_id = DEV_CODE;
      SRC_PROT: rd_id = {15'd0, blk_prot[rd_blk]};
      default:  rd_id = 16'd0;
    endcase
    rd_src = src;
  end
endmodule

// File: rtl/fcd_top.sv
module fcd_top
  import fcd_pkg::*;
#(
  parameter int          ADDR_W   = 18,
  parameter int          DATA_W   = 16,
  parameter int          BLK_W    = 6,
  parameter int          KEY_W    = 11,
  parameter logic [15:0] DEV_CODE = 16'h00EE
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_valid,
  output logic                     wr_ready,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic                     wr_alsb,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     byte_mode,
  input  logic [(1<<BLK_W)-1:0]    blk_prot,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [2:0]               rd_src,
  output logic [15:0]              rd_id,
  output logic                     prog_valid,
  input  logic                     prog_ready,
  output logic [ADDR_W:0]          prog_addr,
  output logic [DATA_W-1:0]        prog_data,
  input  logic                     op_done,
  input  logic                     op_err
);
  localparam int BLK_LSB = ADDR_W - BLK_W;

  logic       fire, hit_first, hit_second, launch, tgt_prot;
  fcd_state_e state;

  assign wr_ready = !prog_valid;
  assign fire     = wr_valid && wr_ready;
  assign tgt_prot = blk_prot[wr_addr[ADDR_W-1:BLK_LSB]];

  fcd_addr_match #(.KEY_W(KEY_W)) u_match (
    .key_addr  (wr_addr[KEY_W-1:0]),
    .alsb      (wr_alsb),
    .byte_mode (byte_mode),
    .hit_first (hit_first),
    .hit_second(hit_second)
  );

  fcd_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .hit_first (hit_first),
    .hit_second(hit_second),
    .cmd       (wr_data[7:0]),
    .tgt_prot  (tgt_prot),
    .op_done   (op_done),
    .op_err    (op_err),
    .state     (state),
    .launch    (launch)
  );

  fcd_prog_port #(.PA_W(ADDR_W+1), .DW(DATA_W)) u_prog (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .tgt_addr  ({wr_addr, wr_alsb}),
    .tgt_data  (wr_data),
    .prog_ready(prog_ready),
    .prog_valid(prog_valid),
    .prog_addr (prog_addr),
    .prog_data (prog_data)
  );

  fcd_read_mux #(.BLK_W(BLK_W), .DEV_CODE(DEV_CODE)) u_rmux (
    .state   (state),
    .rd_sel  (rd_addr[1:0]),
    .rd_blk  (rd_addr[ADDR_W-1:BLK_LSB]),
    .blk_prot(blk_prot),
    .rd_src  (rd_src),
    .rd_id   (rd_id)
  );
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int BLK_W  = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_ready,
  input logic                  prog_valid,
  input logic                  prog_ready,
  input logic [ADDR_W:0]       prog_addr,
  input logic [DATA_W-1:0]     prog_data,
  input logic [(1<<BLK_W)-1:0] blk_prot,
  input logic [2:0]            rd_src,
  input logic [15:0]           rd_id
);
  logic [(1<<BLK_W)-1:0] prot_q;
  always_ff @(posedge clk) prot_q <= blk_prot;

  a_r8_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    prog_valid && !prog_ready |=> prog_valid && $stable(prog_addr) && $stable(prog_data));

  a_r8_no_write_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    prog_valid |-> !wr_ready);

  a_r6_no_protected_launch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_valid) |-> !prot_q[prog_addr[ADDR_W:ADDR_W-BLK_W+1]]);

  a_r5_status_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    prog_valid |-> rd_src == 3'd4);

  a_r10_maker_code: assert property (@(posedge clk) disable iff (!rst_n)
    rd_src == 3'd1 |-> rd_id == 16'h0020);
endmodule

bind fcd_top fcd_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_ready  (wr_ready),
  .prog_valid(prog_valid),
  .prog_ready(prog_ready),
  .prog_addr (prog_addr),
  .prog_data (prog_data),
  .blk_prot  (blk_prot),
  .rd_src    (rd_src),
  .rd_id     (rd_id)
);

// File: tb/tb_fcd_top.sv
`timescale 1ns/1ps
module tb_fcd_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 0, wr_alsb = 0, byte_mode = 0, prog_ready = 1, op_done = 0, op_err = 0;
  logic [17:0] wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0;
  logic [63:0] blk_prot = 0;
  logic wr_ready, prog_valid;
  logic [2:0] rd_src;
  logic [15:0] rd_id, prog_data;
  logic [18:0] prog_addr;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  fcd_top dut (.*);

  localparam int M_RD=0, M_U1=1, M_U2=2, M_PA=3, M_AU=4, M_BZ=5, M_ER=6, M_FM=7, M_FP=8, M_FX=9;
  int m_st = M_RD;
  bit m_fe = 0, m_fr = 0, m_pv = 0;
  logic [18:0] m_pa = 0;
  logic [15:0] m_pd = 0;

  function automatic bit key1(input logic [17:0] a, input logic l, input logic bm);
    return bm ? ({a[10:0], l} == 12'hAAA) : (a[10:0] == 11'h555);
  endfunction
  function automatic bit key2(input logic [17:0] a, input logic l, input logic bm);
    return bm ? ({a[10:0], l} == 12'h555) : (a[10:0] == 11'h2AA);
  endfunction
  function automatic int exp_src(input logic [17:0] ra);
    if (m_st == M_BZ || m_st == M_ER) return 4;
    if (m_st == M_AU) return (ra[1:0] == 2'b11) ? 0 : int'(ra[1:0]) + 1;
    return 0;
  endfunction
  function automatic logic [15:0] exp_id(input logic [17:0] ra);
    case (exp_src(ra))
      1: return 16'h0020;
      2: return 16'h00EE;
      3: return {15'd0, blk_prot[ra[17:12]]};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // model of one clock edge, from the requirements
  task automatic model_edge();
    bit fire, prot;
    logic [7:0] c;
    fire = wr_valid && !m_pv;
    c    = wr_data[7:0];
    prot = blk_prot[wr_addr[17:12]];
    if (m_pv && prog_ready) m_pv = 0;
    if (m_st == M_BZ) begin
      if (op_done) m_st = op_err ? M_ER : (m_fr ? M_FM : M_RD);
    end else if (fire) begin
      case (m_st)
        M_RD, M_AU, M_ER: begin
          if (c == 8'hF0) m_st = M_RD;
          else if (key1(wr_addr, wr_alsb, byte_mode) && c == 8'hAA) begin m_fe = (m_st == M_ER); m_st = M_U1; end
          else if (m_st != M_ER) m_st = M_RD;
        end
        M_U1: m_st = (key2(wr_addr, wr_alsb, byte_mode) && c == 8'h55) ? M_U2 : (m_fe ? M_ER : M_RD);
        M_U2: begin
          if (c == 8'hF0) m_st = M_RD;
          else if (key1(wr_addr, wr_alsb, byte_mode) && !m_fe)
            m_st = (c == 8'h90) ? M_AU : (c == 8'hA0) ? M_PA : (c == 8'h20) ? M_FM : M_RD;
          else m_st = m_fe ? M_ER : M_RD;
        end
        M_PA, M_FP: begin
          m_fr = (m_st == M_FP);
          if (prot) m_st = m_fr ? M_FM : M_RD;
          else begin m_pv = 1; m_pa = {wr_addr, wr_alsb}; m_pd = wr_data; m_st = M_BZ; end
        end
        M_FM: if (c == 8'hA0) m_st = M_FP; else if (c == 8'h90) m_st = M_FX;
        M_FX: m_st = (c == 8'h00) ? M_RD : M_FM;
        default: m_st = M_RD;
      endcase
    end
  endtask

  function automatic string state_tag();
    case (m_st)
      M_BZ: return "R7";
      M_ER: return "R9";
      M_AU: return "R10";
      M_FM, M_FP, M_FX: return "R11";
      M_U1, M_U2, M_PA: return "R4";
      default: return "R2";
    endcase
  endfunction

  task automatic compare();
    check(state_tag(), 32'(rd_src), 32'(exp_src(rd_addr)));
    check("R10", 32'(rd_id), 32'(exp_id(rd_addr)));
    check("R8", {prog_valid, wr_ready}, {m_pv, !m_pv});
    if (m_pv) check("R5", {prog_addr, prog_data}, {m_pa, m_pd});
  endtask

  bit rnd_ctl = 1;
  // one cycle; drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(input bit wv, input logic [17:0] a, input logic l, input logic [15:0] d);
    wr_valid = wv; wr_addr = a; wr_alsb = l; wr_data = d;
    rd_addr = 18'($urandom);
    if (rnd_ctl) begin
      prog_ready = ($urandom % 10) < 7;
      op_done    = (m_st == M_BZ) && !m_pv && ($urandom % 3 == 0);
      op_err     = ($urandom % 4 == 0);
    end
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  function automatic logic [17:0] ka(input int which, input logic bm);
    logic [17:0] a;
    a = 18'($urandom);
    if (bm) a[10:0] = (which == 1) ? 11'h555 : 11'h2AA;
    else    a[10:0] = (which == 1) ? 11'h555 : 11'h2AA;
    return a;
  endfunction
  function automatic logic kl(input int which, input logic bm);
    return bm ? (which == 2) : 1'($urandom);
  endfunction

  task automatic wr(input logic [17:0] a, input logic l, input logic [15:0] d);
    while (m_pv) cyc(0, 0, 0, 0);
    cyc(1, a, l, d);
  endtask
  task automatic unlock();
    wr(ka(1, byte_mode), kl(1, byte_mode), {8'($urandom), 8'hAA});
    wr(ka(2, byte_mode), kl(2, byte_mode), {8'($urandom), 8'h55});
  endtask
  task automatic cmd3(input logic [7:0] c);
    unlock();
    wr(ka(1, byte_mode), kl(1, byte_mode), {8'($urandom), c});
  endtask
  task automatic finish_op(input bit err);
    rnd_ctl = 0; prog_ready = 1; op_done = 0;
    while (m_st == M_BZ && m_pv) cyc(0, 0, 0, 0);
    op_done = 1; op_err = err;
    cyc(0, 0, 0, 0);
    op_done = 0; op_err = 0; rnd_ctl = 1;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1", {29'd0, rd_src}, 0);
    check("R1", {prog_valid, wr_ready}, 2'b01);

    // R5 word-mode program into unprotected block
    rnd_ctl = 0; prog_ready = 0; op_done = 0;
    blk_prot = 64'h0000_0000_0000_0002;
    cmd3(8'hA0);
    cyc(1, 18'h0_4321, 1'b1, 16'hBEEF);
    check("R5", {prog_valid, prog_addr}, {1'b1, 18'h0_4321, 1'b1});
    cyc(1, ka(1, 0), 0, 16'h00AA);  // R8: not taken while pending
    check("R8", 32'(wr_ready), 0);
    rnd_ctl = 1;
    finish_op(0);
    check("R7", 32'(rd_src), 0);

    // R6 protected target: dropped, no error
    cmd3(8'hA0);
    wr(18'h0_1000 | 18'h55, 0, 16'h1234);
    check("R6", {prog_valid, rd_src}, 4'b0000);

    // R4 deviation: wrong second unlock address
    wr(ka(1, 0), 0, 16'h00AA);
    wr(18'h0_0123, 0, 16'h0055);
    wr(ka(1, 0), 0, 16'h0090);
    check("R4", 32'(rd_src), 0);

    // R3 byte-mode keys with upper bits set, then identifier mode
    byte_mode = 1;
    cmd3(8'h90);
    check("R3", 32'(m_st == M_AU), 1);
    rd_addr = 18'h0_1001; #1;
    check("R3", {rd_src, rd_id}, {3'd2, 16'h00EE});
    // word-mode address in byte mode must not unlock
    wr(18'h3_F555, 0, 16'hFFAA);
    wr(18'h0_02AA, 0, 16'h0055);
    check("R3", 32'(rd_src), 0);
    byte_mode = 0;

    // R9 error then three-write reset
    cmd3(8'hA0);
    wr(18'h2_0000, 0, 16'h0F0F);
    finish_op(1);
    check("R9", 32'(rd_src), 4);
    cmd3(8'h90);
    check("R9", 32'(rd_src), 4);
    unlock();
    wr(18'h1_2345, 0, 16'h00F0);
    check("R2", 32'(rd_src), 0);

    // R11 fast-program mode
    cmd3(8'h20);
    wr(18'h0, 0, 16'h00F0);
    check("R11", 32'(m_st == M_FM), 1);
    wr(18'h3_0000, 0, 16'h00A0);
    wr(18'h0_0777, 0, 16'h5A5A);
    finish_op(0);
    check("R11", 32'(m_st == M_FM), 1);
    wr(18'h0, 0, 16'h0090);
    wr(18'h0, 0, 16'h0000);
    check("R11", 32'(m_st == M_RD), 1);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      int k;
      if (i % 500 == 0) begin
        byte_mode = 1'($urandom);
        blk_prot = {$urandom, $urandom};
      end
      k = $urandom % 10;
      if (k < 3)      cmd3(8'($urandom % 4 == 0 ? 8'h90 : (($urandom % 2) ? 8'hA0 : 8'h20)));
      else if (k < 5) cyc(1, 18'($urandom), 1'($urandom), 16'($urandom));
      else if (k < 6) cyc(1, 18'($urandom), 1'($urandom), ($urandom % 2) ? 16'h00A0 : 16'h0090);
      else if (k < 7) cyc(1, 18'($urandom), 0, 16'h00F0);
      else if (k < 8) unlock();
      else            cyc(1'($urandom), 18'($urandom), 0, 16'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule